// File: doc/BRIEF.md
# Request-Paced Byte Mover Channel

This block is one channel of a direct memory access engine that shifts bytes between a memory buffer and a single data register inside a peripheral. Software sets up two addresses, a byte count, a direction, a two-bit priority and two interrupt enables, and then turns the channel on. The peripheral then sets the pace. Each strobe on its request line means either "my transmit buffer is empty" or "my receive buffer holds a byte". For each strobe the channel carries out one read beat and one write beat on a simple single-beat bus.

For each byte, the channel steps its memory pointer by one and lowers its remaining count by one. The peripheral address does not change. When the count reaches half of its starting value the channel raises a half flag. When the count reaches zero it raises a full flag, sends a one-cycle end-of-transfer pulse back to the peripheral and turns itself off. A peripheral whose own buffer interrupt is switched on cannot be paced by DMA, so an enable request made while that interrupt is on is refused.

Top module: `pdma_channel`

## Requirements
- R1: After reset, ch_en, half_flag, full_flag, irq, eot and bus_req are all 0, and remaining is 0.
- R2: A write with reg_sel=3 loads the configuration: bit 0 enable, bit 1 direction, bit 2 half-interrupt enable, bit 3 full-interrupt enable, bits 5:4 priority. The same write clears both flags and drops any held request. The enable bit takes effect only when buf_irq_en is low.
- R3: reg_sel=0 loads the peripheral address, reg_sel=1 the memory address and reg_sel=2 the count. With direction 1, a transfer reads the memory address and then writes the byte it read to the peripheral address. With direction 0, it reads the peripheral address and then writes that byte to the memory address.
- R4: A transfer starts only while the channel is enabled, idle and has a nonzero count, and only on a request strobe in that cycle or a request held from earlier. bus_req is never high while the channel is disabled.
- R5: Each completed write beat lowers remaining by one and raises the memory address by one. The peripheral address stays the same.
- R6: A strobe that arrives while a transfer is in progress is held and serviced exactly once. Several strobes that arrive before that service count as one request.
- R7: half_flag sets once remaining is at or below floor(start count / 2) while the channel is enabled. It clears only on a configuration write.
- R8: In the cycle after an enabled, idle channel holds a count of zero, full_flag sets, ch_en clears and eot is high for exactly one cycle.
- R9: A channel enabled with a count of zero completes as in R8 without issuing any bus beat.
- R10: irq is high exactly when (half_flag and half-interrupt enable) or (full_flag and full-interrupt enable).
- R11: prio shows the priority field from the last configuration write.
- R12: While bus_req is high and bus_ack is low, bus_addr, bus_we and bus_wdata hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 peripheral addr, 1 memory addr, 2 count, 3 config |
| reg_wdata | input | AW | Register write data |
| periph_req | input | 1 | Peripheral pacing strobe (transmit empty or receive full) |
| buf_irq_en | input | 1 | Peripheral buffer interrupt is enabled; blocks channel enable |
| bus_req | output | 1 | Bus beat request |
| bus_we | output | 1 | Beat is a write |
| bus_addr | output | AW | Beat address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid with bus_ack |
| bus_ack | input | 1 | Beat accepted this cycle |
| ch_en | output | 1 | Channel enabled |
| remaining | output | AW | Bytes left to move |
| prio | output | 2 | Priority field |
| half_flag | output | 1 | Half-way flag |
| full_flag | output | 1 | Completion flag |
| irq | output | 1 | Interrupt request |
| eot | output | 1 | One-cycle end-of-transfer pulse to the peripheral |

## Verification
A new pacing strobe can arrive in the same cycle that the write beat of the previous byte is acknowledged. The held-request logic and the count decrement then act on the same edge. The bench provokes this by issuing a second strobe exactly two cycles after the first while acknowledges return at once. It then checks that remaining drops by exactly two. A count of one provokes a second collision, where the half and full flags set on the same edge. A cycle-accurate model in the bench judges every bus signal and flag on every clock.

// File: rtl/pdma_channel.sv
module pdma_channel #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  input  logic          periph_req,
  input  logic          buf_irq_en,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ack,
  output logic          ch_en,
  output logic [AW-1:0] remaining,
  output logic [1:0]    prio,
  output logic          half_flag,
  output logic          full_flag,
  output logic          irq,
  output logic          eot
);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t           st;
  logic [AW-1:0] p_addr, m_addr, start_cnt;
  logic [DW-1:0] hold;
  logic          to_periph, hie, fie, pend;

  wire cfg_wr  = reg_we && reg_sel == 2'd3;
  wire idle    = st == S_IDLE;
  wire take    = ch_en && idle && remaining != '0 && (pend || periph_req);
  wire done    = ch_en && idle && remaining == '0;
  wire half_hit = ch_en && !half_flag && remaining <= (start_cnt >> 1);
  wire wr_done = st == S_WR && bus_ack;

  assign bus_req   = !idle;
  assign bus_we    = st == S_WR;
  assign bus_addr  = ((st == S_RD) == to_periph) ? m_addr : p_addr;
  assign bus_wdata = hold;
  assign irq       = (half_flag && hie) || (full_flag && fie);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      p_addr    <= '0;
      m_addr    <= '0;
      remaining <= '0;
      start_cnt <= '0;
      hold      <= '0;
      ch_en     <= 1'b0;
      to_periph <= 1'b0;
      hie       <= 1'b0;
      fie       <= 1'b0;
      prio      <= 2'd0;
      pend      <= 1'b0;
      half_flag <= 1'b0;
      full_flag <= 1'b0;
      eot       <= 1'b0;
    end else begin
      eot <= 1'b0;

      if (reg_we && reg_sel == 2'd0) p_addr <= reg_wdata;

      if (reg_we && reg_sel == 2'd1) m_addr <= reg_wdata;
      else if (wr_done)              m_addr <= m_addr + 1'b1;

      if (reg_we && reg_sel == 2'd2) remaining <= reg_wdata;
      else if (wr_done)              remaining <= remaining - 1'b1;

      if (cfg_wr) begin
        ch_en     <= reg_wdata[0] && !buf_irq_en;
        to_periph <= reg_wdata[1];
        hie       <= reg_wdata[2];
        fie       <= reg_wdata[3];
        prio      <= reg_wdata[5:4];
        start_cnt <= remaining;
        half_flag <= 1'b0;
        full_flag <= 1'b0;
        pend      <= 1'b0;
        st        <= S_IDLE;
      end else begin
        if (half_hit) half_flag <= 1'b1;
        if (done) begin
          ch_en     <= 1'b0;
          full_flag <= 1'b1;
          eot       <= 1'b1;
          pend      <= 1'b0;
        end else if (take) begin
          pend <= 1'b0;
        end else if (periph_req && ch_en) begin
          pend <= 1'b1;
        end
        unique case (st)
          S_IDLE: if (take) st <= S_RD;
          S_RD:   if (bus_ack) begin
                    hold <= bus_rdata;
                    st   <= S_WR;
                  end
          S_WR:   if (bus_ack) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

module pdma_channel_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic          buf_irq_en,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_ack,
  input logic          ch_en,
  input logic [AW-1:0] remaining,
  input logic          half_flag,
  input logic          full_flag,
  input logic          eot
);

  a_r12_beat_stable: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  a_r4_no_beat_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en |-> !bus_req);

  a_r4_start_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> remaining != '0);

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && bus_ack && !reg_we |=> remaining == $past(remaining) - 1'b1);

  a_r8_eot_single: assert property (@(posedge clk) disable iff (!rst_n)
    eot |=> !eot);

  a_r8_eot_state: assert property (@(posedge clk) disable iff (!rst_n)
    eot |-> full_flag && !ch_en);

  a_r7_half_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(half_flag) |-> $past(reg_we));

  a_r2_enable_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ch_en) |-> $past(!buf_irq_en));

endmodule

bind pdma_channel pdma_channel_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .buf_irq_en(buf_irq_en),
  .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_ack(bus_ack), .ch_en(ch_en), .remaining(remaining),
  .half_flag(half_flag), .full_flag(full_flag), .eot(eot)
);

// File: tb/pdma_channel_test.sv
module pdma_channel_test;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          reg_we = 0;
  logic [1:0]    reg_sel = 0;
  logic [AW-1:0] reg_wdata = 0;
  logic          preq = 0;
  logic          buf_irq_en = 0;
  logic          ack_en = 1;
  logic          bus_req, bus_we, bus_ack, ch_en, half_flag, full_flag, irq, eot;
  logic [AW-1:0] bus_addr, remaining;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic [1:0]    prio;

  logic [DW-1:0] mem [256];

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign bus_ack   = bus_req & ack_en;
  assign bus_rdata = mem[bus_addr[7:0]];

  pdma_channel #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .periph_req(preq), .buf_irq_en(buf_irq_en),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .ch_en(ch_en), .remaining(remaining), .prio(prio),
    .half_flag(half_flag), .full_flag(full_flag), .irq(irq), .eot(eot)
  );

  always @(posedge clk)
    if (bus_req && bus_we && bus_ack) mem[bus_addr[7:0]] <= bus_wdata;

  // reference model
  int m_ph, m_cnt, m_init, m_pa, m_ma, m_prio, m_data;
  bit m_en, m_dir, m_hie, m_fie, m_pend, m_half, m_full, m_eot;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_init = 0; m_pa = 0; m_ma = 0; m_prio = 0; m_data = 0;
      m_en = 0; m_dir = 0; m_hie = 0; m_fie = 0; m_pend = 0; m_half = 0; m_full = 0; m_eot = 0;
    end else begin
      bit ack, take, done, hhit;
      ack  = ack_en && m_ph != 0;
      take = m_en && m_ph == 0 && m_cnt != 0 && (m_pend || preq);
      done = m_en && m_ph == 0 && m_cnt == 0;
      hhit = m_en && !m_half && m_cnt <= m_init / 2;
      m_eot = 0;
      if (m_ph == 1 && ack) m_data = mem[(m_dir ? m_ma : m_pa) % 256];
      if (reg_we && reg_sel == 0) m_pa = int'(reg_wdata);
      if (reg_we && reg_sel == 1) m_ma = int'(reg_wdata);
      else if (m_ph == 2 && ack) m_ma = (m_ma + 1) % 65536;
      if (reg_we && reg_sel == 2) m_cnt = int'(reg_wdata);
      else if (m_ph == 2 && ack) m_cnt = m_cnt - 1;
      if (reg_we && reg_sel == 3) begin
        m_en = reg_wdata[0] && !buf_irq_en;
        m_dir = reg_wdata[1]; m_hie = reg_wdata[2]; m_fie = reg_wdata[3];
        m_prio = int'(reg_wdata[5:4]);
        m_init = m_cnt; m_half = 0; m_full = 0; m_pend = 0; m_ph = 0;
      end else begin
        if (hhit) m_half = 1;
        if (done) begin m_en = 0; m_full = 1; m_eot = 1; m_pend = 0; end
        else if (take) m_pend = 0;
        else if (preq && m_en) m_pend = 1;
        if (m_ph == 0 && take) m_ph = 1;
        else if (m_ph != 0 && ack) m_ph = (m_ph == 1) ? 2 : 0;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  int cycle_no = 0;
  always @(negedge clk) begin
    cycle_no++;
    if (rst_n && cycle_no > 1) begin
      chk("R4 bus_req", int'(bus_req), int'(m_ph != 0));
      chk("R3 bus_we", int'(bus_we), int'(m_ph == 2));
      if (m_ph == 1) chk("R3 read addr", int'(bus_addr), m_dir ? m_ma : m_pa);
      if (m_ph == 2) chk("R3 write addr", int'(bus_addr), m_dir ? m_pa : m_ma);
      if (m_ph == 2) chk("R3 write data", int'(bus_wdata), m_data);
      chk("R5 remaining", int'(remaining), m_cnt);
      chk("R8 ch_en", int'(ch_en), int'(m_en));
      chk("R7 half_flag", int'(half_flag), int'(m_half));
      chk("R8 full_flag", int'(full_flag), int'(m_full));
      chk("R8 eot", int'(eot), int'(m_eot));
      chk("R10 irq", int'(irq), int'((m_half && m_hie) || (m_full && m_fie)));
      chk("R11 prio", int'(prio), m_prio);
    end
  end

  int beats = 0;
  always @(posedge clk) if (bus_req) beats++;

  task automatic wr(input int sel, input int val);
    @(negedge clk);
    reg_we = 1; reg_sel = 2'(sel); reg_wdata = AW'(val);
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic pulse;
    @(negedge clk); preq = 1;
    @(negedge clk); preq = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ch_en", int'(ch_en), 0);
    chk("R1 flags", int'({half_flag, full_flag, irq, eot}), 0);
    chk("R1 bus_req", int'(bus_req), 0);

    // R3 memory-to-peripheral, 5 bytes
    wr(0, 'hF0); wr(1, 'h20); wr(2, 5); wr(3, 'h3F);
    for (int i = 0; i < 5; i++) begin pulse; idle(5); end
    idle(3);
    chk("R3 last byte at peripheral", int'(mem[8'hF0]), int'(8'(4'h4 * 7 + 3 + 7 * 'h20)));
    chk("R8 done tx", int'({full_flag, ch_en}), 2);

    // R6 peripheral-to-memory with stalls and merged requests
    wr(0, 'hF0); wr(1, 'h40); wr(2, 4); wr(3, 'h15);
    mem[8'hF0] = 8'hA1;
    ack_en = 0;
    pulse; idle(1);
    pulse; pulse;
    idle(3);
    ack_en = 1;
    idle(8);
    chk("R6 merged requests", int'(remaining), 2);
    mem[8'hF0] = 8'hB2; pulse; idle(6);
    mem[8'hF0] = 8'hC3; pulse; idle(8);
    chk("R3 rx byte0", int'(mem[8'h40]), 'hA1);
    chk("R3 rx byte2", int'(mem[8'h42]), 'hB2);
    chk("R3 rx byte3", int'(mem[8'h43]), 'hC3);
    chk("R7 half rx", int'(half_flag), 1);

    // Verification collision: strobe in the cycle of the write acknowledge
    wr(0, 'hF0); wr(1, 'h60); wr(2, 6); wr(3, 'h0B);
    pulse; pulse;
    idle(8);
    chk("R6 strobe at write ack", int'(remaining), 4);
    for (int i = 0; i < 4; i++) begin pulse; idle(4); end
    idle(3);
    chk("R8 finished", int'(full_flag), 1);

    // R7/R8 count of one: half and full together
    wr(1, 'h80); wr(2, 1); wr(3, 'h0F);
    pulse; idle(6);
    chk("R7 half with count one", int'(half_flag), 1);
    chk("R10 irq", int'(irq), 1);

    // R9 zero count
    wr(2, 0);
    beats = 0;
    wr(3, 'h09);
    idle(4);
    chk("R9 no beats", beats, 0);
    chk("R9 full", int'(full_flag), 1);

    // R2 blocked by peripheral buffer interrupt
    buf_irq_en = 1;
    wr(2, 3); wr(3, 'h21);
    pulse; idle(4);
    chk("R2 enable refused", int'(ch_en), 0);
    chk("R2 no transfer", int'(remaining), 3);
    buf_irq_en = 0;

    // R4 request while disabled is ignored, then enable services nothing held
    pulse;
    wr(3, 'h03);
    idle(5);
    chk("R4 no stale request", int'(remaining), 3);
    pulse; idle(6);
    chk("R5 one step", int'(remaining), 2);
    idle(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule